// File: doc/BRIEF.md
# Self-Repairing Triplicated Counter

This block keeps a binary up-counter in three identical register copies so that a single-event flip in one copy neither shows at the outputs nor lasts. Each copy has a bitwise majority voter of its own. The voted value, not the copy's own stored value, feeds that copy's increment logic. A corrupted copy is therefore overwritten with the majority value plus the increment at the next clock edge, instead of only being outvoted.

The block drives three voted count outputs, one per voter, and does not merge them into one. A single upset output driver then cannot defeat a downstream vote. A mismatch flag reports any cycle in which a stored copy differs from the majority. Three flip-mask inputs, one per copy, let verification corrupt a chosen copy's register at a chosen edge. In normal use these inputs are tied to zero.

Top module: `tmr_counter`

## Requirements
- R1: While `rst` is high at a rising edge, all three copies load zero. After that edge, all three outputs read zero and `mismatch` is low.
- R2: With no flip active, `en` high adds one to the voted count at each edge, and `en` low leaves it unchanged.
- R3: The count wraps from 2^W-1 to zero.
- R4: `cnt_a`, `cnt_b` and `cnt_c` are driven by three separate voters. Each voter takes bit i of its output as the majority of bit i across the three copies, so the three outputs carry equal values.
- R5: A bit set in `flip_a`, `flip_b` or `flip_c` at an edge inverts that bit of the value that copy A, B or C would otherwise store.
- R6: `mismatch` is high in exactly those cycles in which a stored copy differs from the majority. A single-copy flip raises it for one cycle only.
- R7: After a flip in one copy, the outputs follow the undisturbed count in every cycle, and the corrupted copy holds the correct value again after the next edge.
- R8: `rst` has priority over the flip inputs. A flip applied at a reset edge leaves all copies at zero.
- R9: If two copies receive the same flip bits at one edge, the majority adopts the corrupted value. The outputs show it, and all three copies hold it plus the increment after the next edge.
- R10: If two copies receive flips in disjoint bit positions at one edge, the bitwise majority still yields the undisturbed count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| flip_a | input | W | Bit-flip mask for copy A (verification) |
| flip_b | input | W | Bit-flip mask for copy B (verification) |
| flip_c | input | W | Bit-flip mask for copy C (verification) |
| cnt_a | output | W | Voted count from voter A |
| cnt_b | output | W | Voted count from voter B |
| cnt_c | output | W | Voted count from voter C |
| mismatch | output | 1 | A stored copy differs from the majority |

## Verification
The bench builds the counter with W = 8, which brings the wrap from 255 to 0 within a few hundred cycles. With the full default width, reaching the wrap would take 65536 cycles. The narrow width also lets masks such as 0x81 cover both end bits. Double-copy flips are applied with the same mask and with disjoint masks, and a flip is applied at a reset edge, so the voter's per-bit majority and the reset priority are each exercised where they decide the outcome.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_REP = 3;

  // per-bit two-of-three majority
  function automatic logic maj_bit(input logic x0, input logic x1, input logic x2);
    return (x0 & x1) | (x0 & x2) | (x1 & x2);
  endfunction
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int W = 16
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  output logic [W-1:0] voted,
  output logic         disagree
);
  import tmr_pkg::*;

  for (genvar gb = 0; gb < W; gb++) begin : g_bit
    assign voted[gb] = maj_bit(x0[gb], x1[gb], x2[gb]);
  end

  assign disagree = (x0 != voted) | (x1 != voted) | (x2 != voted);
endmodule

// File: rtl/tmr_replica.sv
module tmr_replica #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] voted,
  input  logic [W-1:0] flip,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] bump(input logic [W-1:0] v, input logic inc);
    return v + {{(W-1){1'b0}}, inc};
  endfunction

  logic [W-1:0] next_q;
  assign next_q = bump(voted, en) ^ flip;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= next_q;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] flip_a,
  input  logic [W-1:0] flip_b,
  input  logic [W-1:0] flip_c,
  output logic [W-1:0] cnt_a,
  output logic [W-1:0] cnt_b,
  output logic [W-1:0] cnt_c,
  output logic         mismatch
);
  import tmr_pkg::*;

  logic [W-1:0]       rep_q    [NUM_REP];
  logic [W-1:0]       rep_vote [NUM_REP];
  logic [W-1:0]       rep_flip [NUM_REP];
  logic [NUM_REP-1:0] rep_dis;

  assign rep_flip[0] = flip_a;
  assign rep_flip[1] = flip_b;
  assign rep_flip[2] = flip_c;

  for (genvar gi = 0; gi < NUM_REP; gi++) begin : g_rep
    tmr_voter #(.W(W)) u_vote (
      .x0       (rep_q[0]),
      .x1       (rep_q[1]),
      .x2       (rep_q[2]),
      .voted    (rep_vote[gi]),
      .disagree (rep_dis[gi])
    );

    tmr_replica #(.W(W)) u_rep (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .voted (rep_vote[gi]),
      .flip  (rep_flip[gi]),
      .q     (rep_q[gi])
    );
  end

  assign cnt_a    = rep_vote[0];
  assign cnt_b    = rep_vote[1];
  assign cnt_c    = rep_vote[2];
  assign mismatch = |rep_dis;
endmodule

module tmr_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [W-1:0] flip_a,
  input logic [W-1:0] flip_b,
  input logic [W-1:0] flip_c,
  input logic [W-1:0] cnt_a,
  input logic [W-1:0] cnt_b,
  input logic [W-1:0] cnt_c,
  input logic         mismatch
);
  logic no_flip;
  logic one_flip;
  assign no_flip  = (flip_a == '0) && (flip_b == '0) && (flip_c == '0);
  assign one_flip = $countones({flip_a != '0, flip_b != '0, flip_c != '0}) == 1;

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (cnt_a == '0) && (cnt_b == '0) && (cnt_c == '0) && !mismatch);

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (en && no_flip) |=> cnt_a == $past(cnt_a) + 1'b1);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!en && no_flip) |=> $stable(cnt_a));

  p_outputs_agree_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_a == cnt_b) && (cnt_b == cnt_c));

  p_flip_flags_r6: assert property (@(posedge clk) disable iff (rst)
    one_flip |=> mismatch);

  p_flag_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (mismatch && no_flip) |=> !mismatch);

  p_flip_hidden_r7: assert property (@(posedge clk) disable iff (rst)
    one_flip |=> cnt_b == $past(cnt_b) + {{(W-1){1'b0}}, $past(en)});
endmodule

bind tmr_counter tmr_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en(en),
  .flip_a(flip_a), .flip_b(flip_b), .flip_c(flip_c),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_c(cnt_c), .mismatch(mismatch)
);

// File: tb/sim_tmr_counter.sv
`timescale 1ns/1ps
module sim_tmr_counter;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [W-1:0] flip_a = '0, flip_b = '0, flip_c = '0;
  logic [W-1:0] cnt_a, cnt_b, cnt_c;
  logic         mismatch;

  int checks = 0;
  int failures = 0;
  int rep [3];
  string tag = "R1";

  always #2.5 clk = ~clk;

  tmr_counter #(.W(W)) u0 (
    .clk(clk), .rst(rst), .en(en),
    .flip_a(flip_a), .flip_b(flip_b), .flip_c(flip_c),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_c(cnt_c), .mismatch(mismatch)
  );

  // majority by counting ones per bit position
  function automatic int vote_of(input int a, input int b, input int c);
    int r = 0;
    for (int k = 0; k < W; k++) begin
      int ones = ((a >> k) & 1) + ((b >> k) & 1) + ((c >> k) & 1);
      if (ones >= 2) r = r | (1 << k);
    end
    return r;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int v = vote_of(rep[0], rep[1], rep[2]);
    int mm = (rep[0] != v || rep[1] != v || rep[2] != v) ? 1 : 0;
    check(tag, "cnt_a", int'(cnt_a), v);
    check(tag, "cnt_b", int'(cnt_b), v);
    check(tag, "cnt_c", int'(cnt_c), v);
    check(tag, "mismatch", int'(mismatch), mm);
  endtask

  // drive at negedge, advance model, sample at next negedge
  task automatic step(input logic r, input logic e, input int fa, input int fb, input int fc);
    int v;
    int f [3];
    rst = r; en = e;
    flip_a = fa[W-1:0]; flip_b = fb[W-1:0]; flip_c = fc[W-1:0];
    f[0] = fa; f[1] = fb; f[2] = fc;
    v = vote_of(rep[0], rep[1], rep[2]);
    for (int i = 0; i < 3; i++)
      rep[i] = r ? 0 : (((v + (e ? 1 : 0)) & MASK) ^ f[i]);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #1ms;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) rep[i] = 0;
    @(negedge clk);
    tag = "R1";
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    check("R1", "cnt_a after reset", int'(cnt_a), 0);

    tag = "R2";
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0);
    check("R2", "count after 10 enables", int'(cnt_a), 10);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);
    check("R2", "held count", int'(cnt_b), 10);

    // single flip in A while counting
    tag = "R5";
    step(0, 1, 'h08, 0, 0);
    check("R6", "flag after single flip", int'(mismatch), 1);
    check("R7", "count hidden", int'(cnt_c), 11);
    tag = "R7";
    step(0, 1, 0, 0, 0);
    check("R6", "flag cleared after repair", int'(mismatch), 0);
    check("R7", "count after repair", int'(cnt_a), 12);

    tag = "R5";
    step(0, 0, 0, 'h81, 0);
    step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 'hFF);
    step(0, 1, 0, 0, 0);
    check("R4", "outputs equal", int'(cnt_a ^ cnt_c), 0);

    // disjoint double flips
    tag = "R10";
    step(0, 1, 'h01, 'h02, 0);
    check("R10", "disjoint double flip hidden", int'(cnt_a), 15);
    step(0, 1, 0, 0, 0);

    // identical double flip: majority takes the corrupted value
    tag = "R9";
    step(0, 0, 'h40, 'h40, 0);
    check("R9", "majority corrupted", int'(cnt_b), 16 ^ 'h40);
    check("R6", "flag with double flip", int'(mismatch), 1);
    step(0, 1, 0, 0, 0);
    check("R9", "all copies converge", int'(cnt_c), (16 ^ 'h40) + 1);

    // flip during reset
    tag = "R8";
    step(1, 1, 'h0F, 'hF0, 'h33);
    check("R8", "reset wins over flips", int'(cnt_a), 0);
    check("R8", "no mismatch after reset", int'(mismatch), 0);

    // wrap
    tag = "R3";
    for (int i = 0; i < 255; i++) step(0, 1, 0, 0, 0);
    check("R3", "top value", int'(cnt_a), MASK);
    step(0, 1, 0, 0, 0);
    check("R3", "wrapped to zero", int'(cnt_a), 0);
    step(0, 1, 0, 'h80, 0);
    step(0, 1, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule